// File: doc/BRIEF.md
# Interrupt Entry Controller for an 8-bit CPU

This block sits next to an 8-bit processor core. At every instruction boundary it decides whether the core should enter a non-maskable or a maskable interrupt handler. It holds the two interrupt-enable flip-flops: a live enable, which gates maskable requests, and a shadow copy. A non-maskable entry leaves the shadow copy alone, so a return-from-NMI strobe can restore the live enable afterwards. When the block takes an entry, it supplies the return address the core must push, the new program counter and the number of clock states the entry costs. When the entry comes from the maskable source, it also returns a one-hot acknowledge for the request it served.

Maskable requests are latched into a pending bitfield, and the lowest-numbered pending bit is served first. The interrupt mode selects how the target address is formed. In mode 0 the data-bus byte is read as a one-byte restart opcode. Mode 1 uses a fixed address. In mode 2 the block outputs a table address built from the I register (high byte) and the data-bus byte (low byte), and flags that the core must fetch the real target from that address. If the core is sitting on a halt opcode, the pushed address skips past it.

Top module: `intr_entry_ctrl`

## Requirements
- R1: After reset both enable flip-flops are 0, no NMI or maskable request is pending, and take_o, fetch_o and ack_o are 0.
- R2: A pulse on nmi_edge_i sets an NMI pending latch. At a boundary the NMI is taken whatever the live enable holds, and it wins over any pending maskable request, which stays pending.
- R3: An NMI entry gives newpc_o = 0x0066, cost_o = 11 and ack_o = 0. It clears the live enable, leaves the shadow enable (iff2_o) as it was, and clears the NMI latch, so the next boundary takes no NMI.
- R4: On any entry, push_o is pc_i + 1 when halted_i is 1 (the opcode at PC is halt) and pc_i otherwise.
- R5: A maskable request is taken only while the live enable is 1. While it is 0, a boundary takes nothing and the request stays pending.
- R6: Requests set through req_set_i bit i stay pending until served. The lowest-numbered pending bit is served first, ack_o is one-hot on that bit, and only that bit is cleared.
- R7: A maskable entry clears both enable flip-flops.
- R8: Mode 0 (mode_i = 0): newpc_o = bus_i[5:3] * 8, which is the restart address of the one-byte restart opcode on the bus. cost_o = 13 and fetch_o = 0.
- R9: Mode 1 (mode_i = 1), and the unused code mode_i = 3: newpc_o = 0x0038, cost_o = 13 and fetch_o = 0.
- R10: Mode 2 (mode_i = 2): newpc_o = {ireg_i, bus_i}, fetch_o = 1 and cost_o = 19.
- R11: ei_i sets both flip-flops, di_i clears both, and retn_i copies the shadow enable into the live enable. di_i beats ei_i, which beats retn_i. An entry taken in the same cycle beats all three strobes.
- R12: iff2_o always shows the shadow enable, so the core can copy it into flag bit 2 (parity/overflow) when it loads the accumulator from I or R.
- R13: The decision is made at the clock edge where boundary_i is 1. take_o and ack_o are 1 only in the cycle after that edge, and a boundary with nothing eligible gives take_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | Instruction boundary: decide entry at this edge |
| nmi_edge_i | input | 1 | One-cycle pulse marking an NMI edge |
| req_set_i | input | NREQ (8) | Pulses that set maskable pending bits |
| mode_i | input | 2 | Interrupt mode 0, 1 or 2 |
| ei_i | input | 1 | Enable-interrupts strobe |
| di_i | input | 1 | Disable-interrupts strobe |
| retn_i | input | 1 | Return-from-NMI strobe |
| halted_i | input | 1 | Opcode at PC is the halt instruction |
| pc_i | input | AW (16) | Current program counter |
| ireg_i | input | 8 | I register |
| bus_i | input | 8 | Data-bus byte supplied by the acknowledging device |
| take_o | output | 1 | Entry taken (one cycle) |
| push_o | output | AW (16) | Return address to push |
| newpc_o | output | AW (16) | New PC, or table address when fetch_o is 1 |
| fetch_o | output | 1 | Core must load PC from the word at newpc_o |
| cost_o | output | CW (5) | Clock states charged for the entry |
| iff2_o | output | 1 | Shadow enable flip-flop |
| ack_o | output | NREQ (8) | One-hot acknowledge of the served request |

## Verification
Entry is tried with a single request while the live enable is clear and then set, which separates gating from selection. A three-bit pending mix served across modes 0 and 2 shows that the lowest-first order and the clearing of one bit at a time are correct, and that each target formula is right. An NMI that arrives together with a maskable request, on a halted core with the shadow enable set, shows NMI priority, the skip past the halt opcode, and the preservation of the shadow enable. The return-from-NMI strobe that follows, and an NMI taken after DI, show how the two flip-flops restore and how NMI ignores the live enable. Simultaneous EI and DI, and the spare mode code 3, cover the tie rules.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;

   typedef enum logic [1:0] {
      MODE_RST   = 2'd0,
      MODE_FIXED = 2'd1,
      MODE_TABLE = 2'd2,
      MODE_SPARE = 2'd3
   } imode_e;

   typedef enum logic [1:0] {
      ENT_NONE = 2'd0,
      ENT_NMI  = 2'd1,
      ENT_MASK = 2'd2
   } entry_e;

   // restart opcode 11ttt111 branches to ttt*8
   function automatic logic [15:0] rst_target(input logic [7:0] opc);
      return {8'h00, 2'b00, opc[5:3], 3'b000};
   endfunction

endpackage

// File: rtl/intr_enable_flops.sv
module intr_enable_flops
   import intr_entry_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  entry_e entry_i,
   input  logic   ei_i,
   input  logic   di_i,
   input  logic   retn_i,
   output logic   live_o,
   output logic   shadow_o
);

   logic live_q, shadow_q;
   logic live_d, shadow_d;

   always_comb begin
      live_d   = live_q;
      shadow_d = shadow_q;
      unique case (entry_i)
         ENT_NMI: begin
            live_d = 1'b0;
         end
         ENT_MASK: begin
            live_d   = 1'b0;
            shadow_d = 1'b0;
         end
         default: begin
            if (di_i) begin
               live_d   = 1'b0;
               shadow_d = 1'b0;
            end else if (ei_i) begin
               live_d   = 1'b1;
               shadow_d = 1'b1;
            end else if (retn_i) begin
               live_d = shadow_q;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q   <= 1'b0;
         shadow_q <= 1'b0;
      end else begin
         live_q   <= live_d;
         shadow_q <= shadow_d;
      end
   end

   assign live_o   = live_q;
   assign shadow_o = shadow_q;

endmodule

// File: rtl/intr_pending.sv
module intr_pending
   import intr_entry_pkg::*;
#(
   parameter int NREQ      = 8,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            nmi_edge_i,
   input  logic [NREQ-1:0] req_set_i,
   input  entry_e          entry_i,
   output logic            nmi_pend_o,
   output logic            any_req_o,
   output logic [NREQ-1:0] grant_o
);

   logic            nmi_q;
   logic [NREQ-1:0] pend_q;
   logic [NREQ-1:0] clr_mask;

   generate
      if (LOW_FIRST) begin : g_low
         logic [NREQ:0] seen;
         assign seen[0] = 1'b0;
         for (genvar i = 0; i < NREQ; i++) begin : g_bit
            assign grant_o[i]  = pend_q[i] & ~seen[i];
            assign seen[i+1]   = seen[i] | pend_q[i];
         end
         assign any_req_o = seen[NREQ];
      end else begin : g_high
         logic [NREQ:0] seen;
         assign seen[NREQ] = 1'b0;
         for (genvar i = 0; i < NREQ; i++) begin : g_bit
            assign grant_o[i] = pend_q[i] & ~seen[i+1];
            assign seen[i]    = seen[i+1] | pend_q[i];
         end
         assign any_req_o = seen[0];
      end
   endgenerate

   assign clr_mask = (entry_i == ENT_MASK) ? grant_o : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_q  <= 1'b0;
         pend_q <= '0;
      end else begin
         if (nmi_edge_i)
            nmi_q <= 1'b1;
         else if (entry_i == ENT_NMI)
            nmi_q <= 1'b0;
         pend_q <= (pend_q & ~clr_mask) | req_set_i;
      end
   end

   assign nmi_pend_o = nmi_q;

endmodule

// File: rtl/intr_target_calc.sv
module intr_target_calc
   import intr_entry_pkg::*;
#(
   parameter int          AW         = 16,
   parameter int          CW         = 5,
   parameter logic [15:0] NMI_VEC    = 16'h0066,
   parameter logic [15:0] FIXED_VEC  = 16'h0038,
   parameter int          NMI_COST   = 11,
   parameter int          RST_COST   = 13,
   parameter int          FIXED_COST = 13,
   parameter int          TABLE_COST = 19
) (
   input  entry_e        entry_i,
   input  logic [1:0]    mode_i,
   input  logic          halted_i,
   input  logic [AW-1:0] pc_i,
   input  logic [7:0]    ireg_i,
   input  logic [7:0]    bus_i,
   output logic [AW-1:0] push_o,
   output logic [AW-1:0] target_o,
   output logic          fetch_o,
   output logic [CW-1:0] cost_o
);

   localparam logic [AW-1:0] ONE = AW'(1);

   assign push_o = halted_i ? (pc_i + ONE) : pc_i;

   always_comb begin
      target_o = AW'(FIXED_VEC);
      fetch_o  = 1'b0;
      cost_o   = CW'(FIXED_COST);
      if (entry_i == ENT_NMI) begin
         target_o = AW'(NMI_VEC);
         cost_o   = CW'(NMI_COST);
      end else begin
         unique case (imode_e'(mode_i))
            MODE_RST: begin
               target_o = AW'(rst_target(bus_i));
               cost_o   = CW'(RST_COST);
            end
            MODE_TABLE: begin
               target_o = AW'({ireg_i, bus_i});
               fetch_o  = 1'b1;
               cost_o   = CW'(TABLE_COST);
            end
            default: begin
               target_o = AW'(FIXED_VEC);
               cost_o   = CW'(FIXED_COST);
            end
         endcase
      end
   end

endmodule

// File: rtl/intr_entry_ctrl.sv
module intr_entry_ctrl
   import intr_entry_pkg::*;
#(
   parameter int          NREQ       = 8,
   parameter int          AW         = 16,
   parameter int          CW         = 5,
   parameter bit          LOW_FIRST  = 1'b1,
   parameter logic [15:0] NMI_VEC    = 16'h0066,
   parameter logic [15:0] FIXED_VEC  = 16'h0038,
   parameter int          NMI_COST   = 11,
   parameter int          RST_COST   = 13,
   parameter int          FIXED_COST = 13,
   parameter int          TABLE_COST = 19
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            boundary_i,
   input  logic            nmi_edge_i,
   input  logic [NREQ-1:0] req_set_i,
   input  logic [1:0]      mode_i,
   input  logic            ei_i,
   input  logic            di_i,
   input  logic            retn_i,
   input  logic            halted_i,
   input  logic [AW-1:0]   pc_i,
   input  logic [7:0]      ireg_i,
   input  logic [7:0]      bus_i,
   output logic            take_o,
   output logic [AW-1:0]   push_o,
   output logic [AW-1:0]   newpc_o,
   output logic            fetch_o,
   output logic [CW-1:0]   cost_o,
   output logic            iff2_o,
   output logic [NREQ-1:0] ack_o
);

   localparam int COST_MAX = (1 << CW) - 1;

   generate
      if (NREQ < 1 || NREQ > 32) begin : g_bad_nreq
         $error("intr_entry_ctrl: NREQ must lie in 1..32");
      end
      if (AW < 16) begin : g_bad_aw
         $error("intr_entry_ctrl: AW must be at least 16");
      end
      if (NMI_COST > COST_MAX || RST_COST > COST_MAX ||
          FIXED_COST > COST_MAX || TABLE_COST > COST_MAX) begin : g_bad_cost
         $error("intr_entry_ctrl: a cost does not fit in CW bits");
      end
   endgenerate

   entry_e          entry;
   logic            iff1_q;
   logic            iff2_q;
   logic            nmi_pend;
   logic            any_req;
   logic [NREQ-1:0] grant;
   logic [AW-1:0]   push_d;
   logic [AW-1:0]   target_d;
   logic            fetch_d;
   logic [CW-1:0]   cost_d;

   always_comb begin
      entry = ENT_NONE;
      if (boundary_i) begin
         if (nmi_pend)
            entry = ENT_NMI;
         else if (iff1_q && any_req)
            entry = ENT_MASK;
      end
   end

   intr_enable_flops u_flops (
      .clk      (clk),
      .rst_n    (rst_n),
      .entry_i  (entry),
      .ei_i     (ei_i),
      .di_i     (di_i),
      .retn_i   (retn_i),
      .live_o   (iff1_q),
      .shadow_o (iff2_q)
   );

   intr_pending #(
      .NREQ      (NREQ),
      .LOW_FIRST (LOW_FIRST)
   ) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .nmi_edge_i (nmi_edge_i),
      .req_set_i  (req_set_i),
      .entry_i    (entry),
      .nmi_pend_o (nmi_pend),
      .any_req_o  (any_req),
      .grant_o    (grant)
   );

   intr_target_calc #(
      .AW         (AW),
      .CW         (CW),
      .NMI_VEC    (NMI_VEC),
      .FIXED_VEC  (FIXED_VEC),
      .NMI_COST   (NMI_COST),
      .RST_COST   (RST_COST),
      .FIXED_COST (FIXED_COST),
      .TABLE_COST (TABLE_COST)
   ) u_calc (
      .entry_i  (entry),
      .mode_i   (mode_i),
      .halted_i (halted_i),
      .pc_i     (pc_i),
      .ireg_i   (ireg_i),
      .bus_i    (bus_i),
      .push_o   (push_d),
      .target_o (target_d),
      .fetch_o  (fetch_d),
      .cost_o   (cost_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_o  <= 1'b0;
         push_o  <= '0;
         newpc_o <= '0;
         fetch_o <= 1'b0;
         cost_o  <= '0;
         ack_o   <= '0;
      end else if (entry != ENT_NONE) begin
         take_o  <= 1'b1;
         push_o  <= push_d;
         newpc_o <= target_d;
         fetch_o <= fetch_d;
         cost_o  <= cost_d;
         ack_o   <= (entry == ENT_MASK) ? grant : '0;
      end else begin
         take_o  <= 1'b0;
         fetch_o <= 1'b0;
         ack_o   <= '0;
      end
   end

   assign iff2_o = iff2_q;

endmodule

// File: rtl/intr_entry_chk.sv
module intr_entry_chk #(
   parameter int          NREQ     = 8,
   parameter int          AW       = 16,
   parameter int          CW       = 5,
   parameter logic [15:0] NMI_VEC  = 16'h0066,
   parameter int          NMI_COST = 11
) (
   input logic            clk,
   input logic            rst_n,
   input logic            boundary_i,
   input logic            ei_i,
   input logic            di_i,
   input logic            take_o,
   input logic [AW-1:0]   newpc_o,
   input logic [CW-1:0]   cost_o,
   input logic            iff2_o,
   input logic [NREQ-1:0] ack_o,
   input logic            iff1_q,
   input logic            nmi_pend
);

   AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_o)); // R6

   AST_ACK_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      !take_o |-> (ack_o == '0)); // R13

   AST_NMI_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && ack_o == '0) |-> (newpc_o == AW'(NMI_VEC) && cost_o == CW'(NMI_COST))); // R3

   AST_NMI_KEEPS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && ack_o == '0) |-> (!iff1_q && iff2_o == $past(iff2_o))); // R3

   AST_MASK_CLEARS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && ack_o != '0) |-> (!iff1_q && !iff2_o)); // R7

   AST_GATED_BY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_i && !iff1_q && !nmi_pend) |=> !take_o); // R5

   AST_EI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (ei_i && !di_i && !boundary_i) |=> (iff1_q && iff2_o)); // R11

   AST_DI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (di_i && !boundary_i) |=> (!iff1_q && !iff2_o)); // R11

   AST_LIVE_NEEDS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
      iff1_q |-> iff2_o); // R12

endmodule

bind intr_entry_ctrl intr_entry_chk #(
   .NREQ     (NREQ),
   .AW       (AW),
   .CW       (CW),
   .NMI_VEC  (NMI_VEC),
   .NMI_COST (NMI_COST)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .boundary_i (boundary_i),
   .ei_i       (ei_i),
   .di_i       (di_i),
   .take_o     (take_o),
   .newpc_o    (newpc_o),
   .cost_o     (cost_o),
   .iff2_o     (iff2_o),
   .ack_o      (ack_o),
   .iff1_q     (iff1_q),
   .nmi_pend   (nmi_pend)
);

// File: tb/intr_entry_ctrl_test.sv
`timescale 1ns/1ps
module intr_entry_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boundary_i = 1'b0;
   logic        nmi_edge_i = 1'b0;
   logic [7:0]  req_set_i = '0;
   logic [1:0]  mode_i = 2'd1;
   logic        ei_i = 1'b0, di_i = 1'b0, retn_i = 1'b0;
   logic        halted_i = 1'b0;
   logic [15:0] pc_i = 16'h0100;
   logic [7:0]  ireg_i = 8'h00, bus_i = 8'hFF;
   logic        take_o, fetch_o, iff2_o;
   logic [15:0] push_o, newpc_o;
   logic [4:0]  cost_o;
   logic [7:0]  ack_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   intr_entry_ctrl uut (
      .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .nmi_edge_i(nmi_edge_i),
      .req_set_i(req_set_i), .mode_i(mode_i), .ei_i(ei_i), .di_i(di_i),
      .retn_i(retn_i), .halted_i(halted_i), .pc_i(pc_i), .ireg_i(ireg_i),
      .bus_i(bus_i), .take_o(take_o), .push_o(push_o), .newpc_o(newpc_o),
      .fetch_o(fetch_o), .cost_o(cost_o), .iff2_o(iff2_o), .ack_o(ack_o)
   );

   task automatic chk(input string rq, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // boundary pulse; outputs sampled just after the deciding edge
   task automatic boundary();
      @(negedge clk) boundary_i = 1'b1;
      @(posedge clk); #1 boundary_i = 1'b0;
   endtask

   task automatic strobe(input bit e, input bit d, input bit r);
      @(negedge clk) begin ei_i = e; di_i = d; retn_i = r; end
      @(posedge clk); #1 begin ei_i = 0; di_i = 0; retn_i = 0; end
   endtask

   task automatic raise(input logic [7:0] m, input bit nmi);
      @(negedge clk) begin req_set_i = m; nmi_edge_i = nmi; end
      @(negedge clk) begin req_set_i = '0; nmi_edge_i = 1'b0; end
   endtask

   task automatic t_reset();
      chk("R1", "take", take_o, 0);
      chk("R1", "ack", ack_o, 0);
      chk("R1", "iff2", iff2_o, 0);
      chk("R1", "fetch", fetch_o, 0);
      boundary();
      chk("R13", "idle boundary take", take_o, 0);
   endtask

   task automatic t_gate_and_mode1();
      raise(8'h08, 0);
      mode_i = 2'd1; pc_i = 16'h0200; halted_i = 0;
      boundary();
      chk("R5", "masked take", take_o, 0);
      strobe(1, 0, 0);
      chk("R11", "EI shadow", iff2_o, 1);
      boundary();
      chk("R5", "enabled take", take_o, 1);
      chk("R6", "ack bit3", ack_o, 8'h08);
      chk("R9", "mode1 pc", newpc_o, 16'h0038);
      chk("R9", "mode1 cost", cost_o, 13);
      chk("R4", "push not halted", push_o, 16'h0200);
      chk("R7", "shadow cleared", iff2_o, 0);
      @(posedge clk); #1;
      chk("R13", "take one cycle", take_o, 0);
   endtask

   task automatic t_order_and_modes();
      raise(8'hA4, 0);
      strobe(1, 0, 0);
      mode_i = 2'd0; bus_i = 8'hEF;
      boundary();
      chk("R6", "lowest first", ack_o, 8'h04);
      chk("R8", "mode0 pc", newpc_o, 16'h0028);
      chk("R8", "mode0 cost", cost_o, 13);
      chk("R8", "mode0 fetch", fetch_o, 0);
      strobe(1, 0, 0);
      mode_i = 2'd2; ireg_i = 8'h12; bus_i = 8'h40;
      boundary();
      chk("R6", "second bit", ack_o, 8'h20);
      chk("R10", "mode2 addr", newpc_o, 16'h1240);
      chk("R10", "mode2 fetch", fetch_o, 1);
      chk("R10", "mode2 cost", cost_o, 19);
      strobe(1, 0, 0);
      mode_i = 2'd3;
      boundary();
      chk("R6", "third bit", ack_o, 8'h80);
      chk("R9", "mode3 pc", newpc_o, 16'h0038);
      strobe(1, 0, 0);
      boundary();
      chk("R6", "all served", take_o, 0);
      strobe(0, 1, 0);
   endtask

   task automatic t_nmi();
      strobe(1, 0, 0);
      raise(8'h01, 1);
      halted_i = 1; pc_i = 16'h1234; mode_i = 2'd1;
      boundary();
      chk("R2", "nmi take", take_o, 1);
      chk("R2", "nmi no ack", ack_o, 0);
      chk("R3", "nmi pc", newpc_o, 16'h0066);
      chk("R3", "nmi cost", cost_o, 11);
      chk("R4", "push halted", push_o, 16'h1235);
      chk("R3", "shadow kept", iff2_o, 1);
      halted_i = 0;
      boundary();
      chk("R3", "nmi latch cleared", take_o, 0);
      strobe(0, 0, 1);
      boundary();
      chk("R11", "RETN restores live", take_o, 1);
      chk("R11", "RETN then ack", ack_o, 8'h01);
      strobe(0, 1, 0);
      raise(8'h00, 1);
      boundary();
      chk("R2", "nmi ignores live", take_o, 1);
      chk("R12", "shadow stays 0", iff2_o, 0);
   endtask

   task automatic t_strobes();
      strobe(1, 1, 0);
      chk("R11", "DI beats EI", iff2_o, 0);
      strobe(1, 0, 0);
      chk("R12", "shadow visible", iff2_o, 1);
      strobe(0, 1, 0);
      chk("R11", "DI clears", iff2_o, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_gate_and_mode1();
      t_order_and_modes();
      t_nmi();
      t_strobes();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule